// File: doc/BRIEF.md
# Two-Sided Mailbox with Doorbells

This block connects two processors, called side A and side B, through a shared register unit. Each side sees an identical 32-bit register window on a simple register bus. A side writes a word into one of four outgoing slots, and the word shows up in the matching incoming slot on the opposite side. Flags on both sides follow each word. The writer's slot stops reading empty, and the reader's slot reads full until the reader fetches the word. When the reader fetches it, the writer's slot reads empty again.

Besides the data slots, each side can ring four doorbells toward the other side. A doorbell carries no data and has no acknowledge. It only sets a pending flag on the far side, and that side clears the flag by writing a one to it. Each side has one level interrupt. The interrupt is high while any of that side's status flags is set together with the matching enable bit in that side's control register.

The register bus has a write strobe, a read strobe, a byte address, write data and read data. Read data is combinational during the read strobe. Any side effect of an access takes place at the clock edge that ends the access.

Top module: `mbox_duplex`

## Requirements
- R1: After reset, on both sides the control register (offset 0x24) reads 0, the status register (offset 0x20) reads 0x00F00000 with only the four transmit-empty bits set, and the interrupt output is low.
- R2: A write to transmit slot n (offset 4n, n = 0..3) latches the word at that clock edge. From the next cycle, the far side's receive slot n (offset 0x10+4n) returns the word, the far status bit 24+(3-n) (receive full) reads 1, and the writer's status bit 20+(3-n) (transmit empty) reads 0.
- R3: A read of receive slot n returns the held word. From the next cycle, the reader's status bit 24+(3-n) reads 0 and the far side's status bit 20+(3-n) reads 1.
- R4: A write to a transmit slot that is not empty replaces the held word. A read of a transmit slot returns the word last written to it.
- R5: Writing 1 to control bit 16+(3-n) sets the far side's doorbell-pending status bit 28+(3-n) at that clock edge. The request bit reads 1 in the cycle right after the write and 0 after that.
- R6: Writing 1 to status bit 28+(3-n) clears that side's doorbell-pending flag n. Writing 0 to the bit leaves the flag unchanged.
- R7: If a doorbell request from the far side and a write-1-to-clear of the same pending flag fall in the same cycle, the flag ends set.
- R8: If one side writes transmit slot n in the same cycle that the far side reads receive slot n, the read returns the old word. Afterwards the receive-full flag stays 1 and the slot holds the new word.
- R9: Control bits 31:20 are the enables and hold the written value: doorbell enable 28+(3-n), receive enable 24+(3-n), transmit enable 20+(3-n). Control bits 15:0 and status bits 19:0 read 0 and ignore writes.
- R10: A side's interrupt is high exactly when some status bit among 31:20 is 1 and the same-numbered control enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid while a_rd is high |
| a_irq | output | 1 | Side A level interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid while b_rd is high |
| b_irq | output | 1 | Side B level interrupt |

## Verification
The bench targets the cases where the two sides touch the same flag in one cycle. In one case a doorbell is rung while the far side clears it; a design that lets the clear win silently drops that doorbell. In the other case a word is written while the far side drains the same slot; a design that lets the read win shows an empty slot that actually holds a fresh word. The bench also checks reversed bit numbering, where a design that numbers channels upward would flag the wrong slot. It further checks that a doorbell request reads 1 for exactly one cycle, that writing zeros to the pending flags clears nothing, and that every cycle the interrupt matches the masked flags, including after a transmit slot refills.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    // word indices inside a side's window (byte address / 4)
    localparam int TX_W0 = 0;
    localparam int RX_W0 = 4;
    localparam int ST_W  = 8;
    localparam int CT_W  = 9;
    // field bases; channel n sits at base + (SLOT_MAX-1-n)
    localparam int SLOT_MAX  = 4;
    localparam int PEND_LSB  = 28;
    localparam int FULL_LSB  = 24;
    localparam int EMPTY_LSB = 20;
    localparam int REQ_LSB   = 16;
    localparam int EN_W      = 32 - EMPTY_LSB;

    function automatic int fld(input int base, input int n);
        return base + (SLOT_MAX - 1) - n;
    endfunction
endpackage

// File: rtl/mbox_lane.sv
module mbox_lane #(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          wr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic [NCH-1:0]          rd_i,
    output logic [NCH-1:0][DW-1:0]  data_o,
    output logic [NCH-1:0]          full_o
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] data;
        logic [NCH-1:0]         full;
    } lane_t;

    lane_t q, d;

    always_comb begin
        d = q;
        for (int n = 0; n < NCH; n++) begin
            if (rd_i[n]) d.full[n] = 1'b0;
            // a fresh word wins over a same-cycle drain
            if (wr_i[n]) begin
                d.full[n] = 1'b1;
                d.data[n] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o = q.data;
    assign full_o = q.full;
endmodule

// File: rtl/mbox_window.sv
module mbox_window
    import mbox_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int AW  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic                    rd_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [DW-1:0]           wdata_i,
    output logic [DW-1:0]           rdata_o,
    input  logic [NCH-1:0][DW-1:0]  tx_word_i,
    input  logic [NCH-1:0]          tx_full_i,
    input  logic [NCH-1:0][DW-1:0]  rx_word_i,
    input  logic [NCH-1:0]          rx_full_i,
    input  logic [NCH-1:0]          bell_in_i,
    output logic [NCH-1:0]          bell_out_o,
    output logic [NCH-1:0]          tx_wr_o,
    output logic [NCH-1:0]          rx_rd_o,
    output logic [DW-1:0]           tx_data_o,
    output logic [DW-1:0]           stat_o,
    output logic [DW-1:0]           ctrl_o
);
    localparam int WW = AW - 2;

    typedef struct packed {
        logic [EN_W-1:0] en;
        logic [NCH-1:0]  req;
        logic [NCH-1:0]  pend;
    } win_t;

    win_t q, d;
    logic [WW-1:0] word;
    logic          hit, st_wr, ct_wr;

    assign word      = addr_i[AW-1:2];
    assign hit       = (addr_i[1:0] == 2'b00);
    assign st_wr     = wr_i && hit && (int'(word) == ST_W);
    assign ct_wr     = wr_i && hit && (int'(word) == CT_W);
    assign tx_data_o = wdata_i;

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            tx_wr_o[n]    = wr_i && hit && (int'(word) == TX_W0 + n);
            rx_rd_o[n]    = rd_i && hit && (int'(word) == RX_W0 + n);
            bell_out_o[n] = ct_wr && wdata_i[fld(REQ_LSB, n)];
        end
    end

    always_comb begin
        d     = q;
        d.req = bell_out_o;
        if (ct_wr) d.en = wdata_i[DW-1 -: EN_W];
        for (int n = 0; n < NCH; n++) begin
            if (st_wr && wdata_i[fld(PEND_LSB, n)]) d.pend[n] = 1'b0;
            // a ring from the far side beats a clear in the same cycle
            if (bell_in_i[n]) d.pend[n] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        stat_o = '0;
        ctrl_o = '0;
        ctrl_o[DW-1 -: EN_W] = q.en;
        for (int n = 0; n < NCH; n++) begin
            stat_o[fld(PEND_LSB, n)]  = q.pend[n];
            stat_o[fld(FULL_LSB, n)]  = rx_full_i[n];
            stat_o[fld(EMPTY_LSB, n)] = ~tx_full_i[n];
            ctrl_o[fld(REQ_LSB, n)]   = q.req[n];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i && hit) begin
            for (int n = 0; n < NCH; n++) begin
                if (int'(word) == TX_W0 + n) rdata_o = tx_word_i[n];
                if (int'(word) == RX_W0 + n) rdata_o = rx_word_i[n];
            end
            if (int'(word) == ST_W) rdata_o = stat_o;
            if (int'(word) == CT_W) rdata_o = ctrl_o;
        end
    end
endmodule

// File: rtl/mbox_duplex.sv
module mbox_duplex
    import mbox_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int AW  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_wr,
    input  logic          a_rd,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_wr,
    input  logic          b_rd,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    localparam logic [DW-1:0] IRQ_MASK = {{EN_W{1'b1}}, {(DW-EN_W){1'b0}}};

    logic [NCH-1:0][DW-1:0] ab_data, ba_data;
    logic [NCH-1:0]         ab_full, ba_full;
    logic [NCH-1:0]         a_tx_wr, b_tx_wr, a_rx_rd, b_rx_rd;
    logic [NCH-1:0]         a_bell, b_bell;
    logic [DW-1:0]          a_tx_data, b_tx_data;
    logic [DW-1:0]          a_stat, a_ctrl, b_stat, b_ctrl;

    mbox_lane #(.NCH(NCH), .DW(DW)) u_ab (
        .clk(clk), .rst_n(rst_n), .wr_i(a_tx_wr), .wdata_i(a_tx_data),
        .rd_i(b_rx_rd), .data_o(ab_data), .full_o(ab_full)
    );

    mbox_lane #(.NCH(NCH), .DW(DW)) u_ba (
        .clk(clk), .rst_n(rst_n), .wr_i(b_tx_wr), .wdata_i(b_tx_data),
        .rd_i(a_rx_rd), .data_o(ba_data), .full_o(ba_full)
    );

    mbox_window #(.NCH(NCH), .DW(DW), .AW(AW)) u_win_a (
        .clk(clk), .rst_n(rst_n), .wr_i(a_wr), .rd_i(a_rd), .addr_i(a_addr),
        .wdata_i(a_wdata), .rdata_o(a_rdata),
        .tx_word_i(ab_data), .tx_full_i(ab_full),
        .rx_word_i(ba_data), .rx_full_i(ba_full),
        .bell_in_i(b_bell), .bell_out_o(a_bell),
        .tx_wr_o(a_tx_wr), .rx_rd_o(a_rx_rd), .tx_data_o(a_tx_data),
        .stat_o(a_stat), .ctrl_o(a_ctrl)
    );

    mbox_window #(.NCH(NCH), .DW(DW), .AW(AW)) u_win_b (
        .clk(clk), .rst_n(rst_n), .wr_i(b_wr), .rd_i(b_rd), .addr_i(b_addr),
        .wdata_i(b_wdata), .rdata_o(b_rdata),
        .tx_word_i(ba_data), .tx_full_i(ba_full),
        .rx_word_i(ab_data), .rx_full_i(ab_full),
        .bell_in_i(a_bell), .bell_out_o(b_bell),
        .tx_wr_o(b_tx_wr), .rx_rd_o(b_rx_rd), .tx_data_o(b_tx_data),
        .stat_o(b_stat), .ctrl_o(b_ctrl)
    );

    assign a_irq = |(a_stat & a_ctrl & IRQ_MASK);
    assign b_irq = |(b_stat & b_ctrl & IRQ_MASK);
endmodule

// File: rtl/mbox_duplex_chk.sv
module mbox_duplex_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        a_wr,
    input logic        a_rd,
    input logic [5:0]  a_addr,
    input logic [3:0]  a_reqw,
    input logic        a_irq,
    input logic [3:0]  a_pend,
    input logic [3:0]  a_req,
    input logic [11:0] a_en,
    input logic        b_wr,
    input logic        b_rd,
    input logic [5:0]  b_addr,
    input logic [3:0]  b_reqw,
    input logic        b_irq,
    input logic [3:0]  b_pend,
    input logic [3:0]  b_req,
    input logic [11:0] b_en,
    input logic [3:0]  ab_full,
    input logic [3:0]  ba_full
);
    // R2
    a_tx_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_addr[5:4] == 2'b00 && a_addr[1:0] == 2'b00) |=> ab_full[$past(a_addr[3:2])]);
    // R2
    b_tx_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && b_addr[5:4] == 2'b00 && b_addr[1:0] == 2'b00) |=> ba_full[$past(b_addr[3:2])]);
    // R3
    b_rx_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rd && b_addr[5:4] == 2'b01 && b_addr[1:0] == 2'b00 &&
         !(a_wr && a_addr == {2'b00, b_addr[3:0]})) |=> !ab_full[$past(b_addr[3:2])]);
    // R3
    a_rx_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd && a_addr[5:4] == 2'b01 && a_addr[1:0] == 2'b00 &&
         !(b_wr && b_addr == {2'b00, a_addr[3:0]})) |=> !ba_full[$past(a_addr[3:2])]);
    // R7
    a_ring_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_addr == 6'h24) |=> ((b_pend & $past(a_reqw)) == $past(a_reqw)));
    // R7
    b_ring_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && b_addr == 6'h24) |=> ((a_pend & $past(b_reqw)) == $past(b_reqw)));
    // R5
    a_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req != 4'h0 && !(a_wr && a_addr == 6'h24)) |=> a_req == 4'h0);
    // R5
    b_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req != 4'h0 && !(b_wr && b_addr == 6'h24)) |=> b_req == 4'h0);
    // R6
    a_pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_pend != 4'h0 && !(a_wr && a_addr == 6'h20)) |=> ((a_pend & $past(a_pend)) == $past(a_pend)));
    // R6
    b_pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_pend != 4'h0 && !(b_wr && b_addr == 6'h20)) |=> ((b_pend & $past(b_pend)) == $past(b_pend)));
    // R10
    a_irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en == 12'h000) |-> !a_irq);
    // R10
    b_irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en == 12'h000) |-> !b_irq);
endmodule

bind mbox_duplex mbox_duplex_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_reqw(a_wdata[19:16]), .a_irq(a_irq),
    .a_pend(a_stat[31:28]), .a_req(a_ctrl[19:16]), .a_en(a_ctrl[31:20]),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_reqw(b_wdata[19:16]), .b_irq(b_irq),
    .b_pend(b_stat[31:28]), .b_req(b_ctrl[19:16]), .b_en(b_ctrl[31:20]),
    .ab_full(ab_full), .ba_full(ba_full)
);

// File: tb/mbox_duplex_tb.sv
module mbox_duplex_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mbox_duplex u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    // reference model; lane s carries words sent by side s (0 = A, 1 = B)
    logic [31:0] m_data [2][4];
    bit   [3:0]  m_full [2];
    bit   [3:0]  m_pend [2];
    bit   [3:0]  m_req  [2];
    bit   [11:0] m_en   [2];
    logic [31:0] got_a, got_b;

    function automatic logic [31:0] exp_stat(input int s);
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            v[31 - n] = m_pend[s][n];
            v[27 - n] = m_full[1 - s][n];
            v[23 - n] = !m_full[s][n];
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_ctrl(input int s);
        logic [31:0] v = '0;
        v[31:20] = m_en[s];
        for (int n = 0; n < 4; n++) v[19 - n] = m_req[s][n];
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input int s, input logic [5:0] ad);
        int w = int'(ad[5:2]);
        if (ad[1:0] != 2'b00) return '0;
        if (w < 4) return m_data[s][w];
        if (w < 8) return m_data[1 - s][w - 4];
        if (w == 8) return exp_stat(s);
        if (w == 9) return exp_ctrl(s);
        return '0;
    endfunction

    function automatic bit exp_irq(input int s);
        return |(exp_stat(s)[31:20] & m_en[s]);
    endfunction

    task automatic model_step(input bit wr [2], input bit rd [2],
                              input logic [5:0] ad [2], input logic [31:0] dt [2]);
        m_req[0] = '0;
        m_req[1] = '0;
        for (int s = 0; s < 2; s++) begin
            int w = int'(ad[s][5:2]);
            if (ad[s][1:0] == 2'b00) begin
                if (rd[s] && w >= 4 && w < 8) m_full[1 - s][w - 4] = 1'b0;
                if (wr[s] && w == 8)
                    for (int n = 0; n < 4; n++) if (dt[s][31 - n]) m_pend[s][n] = 1'b0;
            end
        end
        for (int s = 0; s < 2; s++) begin
            int w = int'(ad[s][5:2]);
            if (wr[s] && ad[s][1:0] == 2'b00) begin
                if (w < 4) begin
                    m_data[s][w] = dt[s];
                    m_full[s][w] = 1'b1;
                end
                if (w == 9) begin
                    m_en[s] = dt[s][31:20];
                    for (int n = 0; n < 4; n++)
                        if (dt[s][19 - n]) begin
                            m_req[s][n] = 1'b1;
                            m_pend[1 - s][n] = 1'b1;
                        end
                end
            end
        end
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic cycle(input string tag,
                         input bit aw, input bit ar, input logic [5:0] aad, input logic [31:0] ad,
                         input bit bw, input bit br, input logic [5:0] bad_, input logic [31:0] bd);
        logic [31:0] ea, eb;
        bit wr [2];
        bit rd [2];
        logic [5:0] adr [2];
        logic [31:0] dt [2];
        wr[0] = aw; wr[1] = bw; rd[0] = ar; rd[1] = br;
        adr[0] = aad; adr[1] = bad_; dt[0] = ad; dt[1] = bd;
        ea = exp_read(0, aad);
        eb = exp_read(1, bad_);
        @(negedge clk);
        a_wr = aw; a_rd = ar; a_addr = aad; a_wdata = ad;
        b_wr = bw; b_rd = br; b_addr = bad_; b_wdata = bd;
        #1;
        got_a = a_rdata;
        got_b = b_rdata;
        if (ar) check({tag, " readA"}, got_a, ea);
        if (br) check({tag, " readB"}, got_b, eb);
        @(posedge clk);
        #1;
        a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
        model_step(wr, rd, adr, dt);
        check({tag, " R10 irqA"}, {31'd0, a_irq}, {31'd0, exp_irq(0)});
        check({tag, " R10 irqB"}, {31'd0, b_irq}, {31'd0, exp_irq(1)});
    endtask

    task automatic wr1(input string tag, input int s, input logic [5:0] ad, input logic [31:0] d);
        if (s == 0) cycle(tag, 1, 0, ad, d, 0, 0, 6'h0, 32'h0);
        else        cycle(tag, 0, 0, 6'h0, 32'h0, 1, 0, ad, d);
    endtask

    task automatic rd1(input string tag, input int s, input logic [5:0] ad);
        if (s == 0) cycle(tag, 0, 1, ad, 32'h0, 0, 0, 6'h0, 32'h0);
        else        cycle(tag, 0, 0, 6'h0, 32'h0, 0, 1, ad, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_full[s] = '0; m_pend[s] = '0; m_req[s] = '0; m_en[s] = '0;
            for (int n = 0; n < 4; n++) m_data[s][n] = '0;
        end
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, against constants
        rd1("R1 statA", 0, 6'h20);
        check("R1 statA const", got_a, 32'h00F00000);
        rd1("R1 ctrlB", 1, 6'h24);
        check("R1 ctrlB const", got_b, 32'h0);
        rd1("R1 statB", 1, 6'h20);
        check("R1 statB const", got_b, 32'h00F00000);
        check("R1 irq", {30'd0, a_irq, b_irq}, 32'h0);

        // R2 / R3 word through slot 2
        wr1("R2 txA2", 0, 6'h08, 32'hDEADBEEF);
        rd1("R2 statB", 1, 6'h20);
        check("R2 fullB bit25", {31'd0, got_b[25]}, 32'd1);
        rd1("R2 statA", 0, 6'h20);
        check("R2 emptyA bit21", {31'd0, got_a[21]}, 32'd0);
        rd1("R3 rxB2", 1, 6'h18);
        check("R3 rxB2 word", got_b, 32'hDEADBEEF);
        rd1("R3 statB", 1, 6'h20);
        check("R3 fullB cleared", {31'd0, got_b[25]}, 32'd0);
        rd1("R3 statA", 0, 6'h20);
        check("R3 emptyA set", {31'd0, got_a[21]}, 32'd1);

        // R4 overwrite
        wr1("R4 txB0 first", 1, 6'h00, 32'h11111111);
        wr1("R4 txB0 second", 1, 6'h00, 32'h22222222);
        rd1("R4 txB0 readback", 1, 6'h00);
        check("R4 readback", got_b, 32'h22222222);
        rd1("R4 rxA0", 0, 6'h10);
        check("R4 rxA0 word", got_a, 32'h22222222);

        // R5 / R6 doorbell channel 3 from A
        wr1("R5 ringA3", 0, 6'h24, 32'h00010000);
        rd1("R5 reqA visible", 0, 6'h24);
        check("R5 req bit16 high", got_a, 32'h00010000);
        rd1("R5 reqA cleared", 0, 6'h24);
        check("R5 req bit16 low", got_a, 32'h0);
        rd1("R5 pendB", 1, 6'h20);
        check("R5 pendB bit28", {31'd0, got_b[28]}, 32'd1);
        wr1("R6 write0", 1, 6'h20, 32'h0);
        rd1("R6 pendB kept", 1, 6'h20);
        check("R6 write0 no effect", {31'd0, got_b[28]}, 32'd1);
        wr1("R6 w1c", 1, 6'h20, 32'h10000000);
        rd1("R6 pendB cleared", 1, 6'h20);
        check("R6 w1c clears", {31'd0, got_b[28]}, 32'd0);

        // R7 ring channel 0 while B clears it in the same cycle
        wr1("R7 preset", 0, 6'h24, 32'h00080000);
        cycle("R7 race", 1, 0, 6'h24, 32'h00080000, 1, 0, 6'h20, 32'h80000000);
        rd1("R7 pendB", 1, 6'h20);
        check("R7 set wins", {31'd0, got_b[31]}, 32'd1);
        wr1("R7 cleanup", 1, 6'h20, 32'hF0000000);

        // R8 write slot 1 while far side drains it
        wr1("R8 old", 0, 6'h04, 32'hAAAA0001);
        cycle("R8 race", 1, 0, 6'h04, 32'hBBBB0002, 0, 1, 6'h14, 32'h0);
        check("R8 old word read", got_b, 32'hAAAA0001);
        rd1("R8 statB", 1, 6'h20);
        check("R8 full stays", {31'd0, got_b[26]}, 32'd1);
        rd1("R8 rxB1", 1, 6'h14);
        check("R8 new word", got_b, 32'hBBBB0002);

        // R9 control and status bit masks
        wr1("R9 ctrl all ones", 1, 6'h24, 32'hFFFFFFFF);
        rd1("R9 ctrl pulse", 1, 6'h24);
        check("R9 ctrl with req", got_b, 32'hFFFF0000);
        rd1("R9 ctrl steady", 1, 6'h24);
        check("R9 ctrl enables only", got_b, 32'hFFF00000);
        wr1("R9 stat low bits", 0, 6'h20, 32'h000FFFFF);
        rd1("R9 statA low ignored", 0, 6'h20);
        check("R9 statA low bits zero", got_a & 32'h000FFFFF, 32'h0);
        wr1("R9 ctrl off", 1, 6'h24, 32'h0);
        wr1("R9 pend clear", 0, 6'h20, 32'hF0000000);

        // R10 transmit-empty interrupt on A channel 3
        wr1("R10 en tx3", 0, 6'h24, 32'h00100000);
        check("R10 irq on empty", {31'd0, a_irq}, 32'd1);
        wr1("R10 fill tx3", 0, 6'h0C, 32'h12345678);
        check("R10 irq off when full", {31'd0, a_irq}, 32'd0);
        rd1("R10 drain", 1, 6'h1C);
        check("R10 irq back", {31'd0, a_irq}, 32'd1);

        // random traffic against the model
        for (int i = 0; i < 600; i++) begin
            int s = int'($urandom_range(0, 1));
            int k = int'($urandom_range(0, 6));
            logic [31:0] d = $urandom;
            logic [1:0] n = 2'($urandom_range(0, 3));
            case (k)
                0: wr1("R2 rnd tx", s, {2'b00, n, 2'b00}, d);
                1: rd1("R3 rnd rx", s, {2'b01, n, 2'b00});
                2: wr1("R5 rnd ctrl", s, 6'h24, d & 32'hFFFF0000 & ~($urandom_range(0, 1) ? 32'h000F0000 : 32'h0));
                3: wr1("R6 rnd stat", s, 6'h20, d);
                4: rd1("R9 rnd stat", s, 6'h20);
                5: rd1("R9 rnd ctrl", s, 6'h24);
                default: rd1("R4 rnd txback", s, {2'b00, n, 2'b00});
            endcase
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule